// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the 16-bit status word of an I2C controller that can act as bus master or as slave. The protocol engine reports what happens on the bus through single-cycle event strobes: start, repeated start, stop, a sampled acknowledge, the start of a master transmission, a bus collision, address matches and byte movements. The CPU side adds two things: a strobe for a write to the transmit data register and a per-bit clear mask. Each flag follows its own set and clear rule. Every flag is a register, so the word shows an event one clock after its strobe.

Software reads the word on `status`. It can clear only the three error flags: bus collision, write collision and receive overflow. Every other flag is owned by the hardware. When a set event and a clear event reach the same flag in the same cycle, the set wins.

Top module: `twi_status_flags`

## Requirements
- R1: After reset all of `status` is 0. Bits 13 to 11 and bits 3 to 0 read 0 at all times.
- R2: Bit 15 takes the value of `ack_nack` (1 = NACK, 0 = ACK) in the cycle after `ev_ack_slot`. Otherwise it holds its value.
- R3: Bit 14 is set after `ev_mtx_begin` and cleared after `ev_ack_slot`.
- R4: Bit 10 is set after `ev_collision`. The only thing that clears it is `clr_mask[10]`.
- R5: Bit 9 is set after `ev_gcall_match` and cleared after `ev_stop`.
- R6: Bit 8 is set after `ev_addr10_hi` and cleared after `ev_stop`.
- R7: Bit 7 is set after `ev_txwr` while `busy` is 1. The only thing that clears it is `clr_mask[7]`. A write while `busy` is 0 does not set it.
- R8: Bit 6 is set after `ev_xfer` while `hold_full` is 1. The only thing that clears it is `clr_mask[6]`. A transfer into an empty holding register does not set it.
- R9: Bit 5 is cleared after `ev_addr_match`. It is set after `ev_txwr` or after `ev_slave_rx`.
- R10: Bit 4 is set after `ev_stop`. It is cleared after `ev_start` or `ev_rstart`.
- R11: `clr_mask` bits other than 10, 7 and 6 have no effect on `status`.
- R12: When a set event and a clear event for the same flag come in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start condition detected |
| ev_rstart | input | 1 | Repeated start detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_ack_slot | input | 1 | End of the slave acknowledge slot |
| ack_nack | input | 1 | Sampled acknowledge value, 1 = NACK |
| ev_mtx_begin | input | 1 | Master transmission starts |
| ev_collision | input | 1 | Bus collision during a master operation |
| ev_addr_match | input | 1 | Device address matched |
| ev_gcall_match | input | 1 | General call address matched |
| ev_addr10_hi | input | 1 | Second byte of a matched 10-bit address |
| ev_slave_rx | input | 1 | Slave data byte received |
| ev_xfer | input | 1 | Shift register moved into the receive holding register |
| hold_full | input | 1 | Holding register still has an unread byte |
| ev_txwr | input | 1 | CPU write to the transmit data register |
| busy | input | 1 | Module busy |
| clr_mask | input | 16 | Software clear strobe, one bit per status bit |
| status | output | 16 | Status word |

## Verification
The bench drives each flag through its set and clear events one cycle at a time and compares the whole 16-bit word after every cycle, so a disturbed neighbouring bit shows up as well as a wrong target bit. The overflow and write-collision flags are each tried with their qualifier high and with it low. This shows whether the qualifier gates the flag. The bench sends a full clear mask while hardware-only flags are set; this separates flags that software can clear from flags it cannot. Stimuli that assert a set and a clear for the same flag in one cycle check the priority rule. Both start flavours are tried against the stop flag.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;
    localparam int W     = 16;
    localparam int NFLAG = 9;

    // flag index -> status bit position
    localparam int F_ACK  = 0;
    localparam int F_TRX  = 1;
    localparam int F_BCOL = 2;
    localparam int F_GC   = 3;
    localparam int F_A10  = 4;
    localparam int F_WCOL = 5;
    localparam int F_ROV  = 6;
    localparam int F_DA   = 7;
    localparam int F_STOP = 8;

    localparam int POS [NFLAG] = '{15, 14, 10, 9, 8, 7, 6, 5, 4};

    // flags that software may clear
    localparam logic [NFLAG-1:0] SW_CLEARABLE =
        (NFLAG'(1) << F_BCOL) | (NFLAG'(1) << F_WCOL) | (NFLAG'(1) << F_ROV);

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
        logic ack_slot;
        logic ack_nack;
        logic mtx_begin;
        logic collision;
        logic addr_match;
        logic gcall_match;
        logic addr10_hi;
        logic slave_rx;
        logic xfer;
        logic hold_full;
        logic txwr;
        logic busy;
    } twi_evt_t;
endpackage

// File: rtl/twi_event_decode.sv
module twi_event_decode
    import twi_stat_pkg::*;
(
    input  twi_evt_t         ev,
    input  logic [W-1:0]     clr_mask,
    output logic [NFLAG-1:0] set_v,
    output logic [NFLAG-1:0] clr_v
);
    logic [NFLAG-1:0] hw_clr;
    logic [NFLAG-1:0] sw_clr;

    always_comb begin
        set_v  = '0;
        hw_clr = '0;

        set_v[F_ACK]   = ev.ack_slot & ev.ack_nack;
        hw_clr[F_ACK]  = ev.ack_slot & ~ev.ack_nack;

        set_v[F_TRX]   = ev.mtx_begin;
        hw_clr[F_TRX]  = ev.ack_slot;

        set_v[F_BCOL]  = ev.collision;

        set_v[F_GC]    = ev.gcall_match;
        hw_clr[F_GC]   = ev.stop;

        set_v[F_A10]   = ev.addr10_hi;
        hw_clr[F_A10]  = ev.stop;

        set_v[F_WCOL]  = ev.txwr & ev.busy;

        set_v[F_ROV]   = ev.xfer & ev.hold_full;

        set_v[F_DA]    = ev.txwr | ev.slave_rx;
        hw_clr[F_DA]   = ev.addr_match;

        set_v[F_STOP]  = ev.stop;
        hw_clr[F_STOP] = ev.start | ev.rstart;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_swclr
        if (SW_CLEARABLE[i]) begin : g_yes
            assign sw_clr[i] = clr_mask[POS[i]];
        end else begin : g_no
            assign sw_clr[i] = 1'b0;
        end
    end

    assign clr_v = hw_clr | sw_clr;
endmodule

// File: rtl/twi_flag_bank.sv
module twi_flag_bank
    import twi_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] clr_v,
    output logic [NFLAG-1:0] flags
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } bank_t;

    bank_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        // set has priority over clear
        state_d.flags = (state_q.flags & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags = state_q.flags;
endmodule

// File: rtl/twi_status_flags.sv
module twi_status_flags
    import twi_stat_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_start,
    input  logic         ev_rstart,
    input  logic         ev_stop,
    input  logic         ev_ack_slot,
    input  logic         ack_nack,
    input  logic         ev_mtx_begin,
    input  logic         ev_collision,
    input  logic         ev_addr_match,
    input  logic         ev_gcall_match,
    input  logic         ev_addr10_hi,
    input  logic         ev_slave_rx,
    input  logic         ev_xfer,
    input  logic         hold_full,
    input  logic         ev_txwr,
    input  logic         busy,
    input  logic [15:0]  clr_mask,
    output logic [15:0]  status
);
    twi_evt_t         ev;
    logic [NFLAG-1:0] set_v, clr_v, flags;

    always_comb begin
        ev.start       = ev_start;
        ev.rstart      = ev_rstart;
        ev.stop        = ev_stop;
        ev.ack_slot    = ev_ack_slot;
        ev.ack_nack    = ack_nack;
        ev.mtx_begin   = ev_mtx_begin;
        ev.collision   = ev_collision;
        ev.addr_match  = ev_addr_match;
        ev.gcall_match = ev_gcall_match;
        ev.addr10_hi   = ev_addr10_hi;
        ev.slave_rx    = ev_slave_rx;
        ev.xfer        = ev_xfer;
        ev.hold_full   = hold_full;
        ev.txwr        = ev_txwr;
        ev.busy        = busy;
    end

    twi_event_decode u_dec (
        .ev       (ev),
        .clr_mask (clr_mask),
        .set_v    (set_v),
        .clr_v    (clr_v)
    );

    twi_flag_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .flags (flags)
    );

    always_comb begin
        status = '0;
        for (int i = 0; i < NFLAG; i++) status[POS[i]] = flags[i];
    end
endmodule

// File: rtl/twi_status_checker.sv
module twi_status_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start,
    input logic        ev_rstart,
    input logic        ev_stop,
    input logic        ev_mtx_begin,
    input logic        ev_collision,
    input logic        ev_gcall_match,
    input logic        ev_txwr,
    input logic        busy,
    input logic [15:0] status
);
    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status[13:11] == 3'b0) && (status[3:0] == 4'b0));

    assert_trx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mtx_begin |=> status[14]);

    assert_bcol_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_collision |=> status[10]);

    assert_gcall_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_gcall_match |=> status[9]);

    assert_wcol_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_txwr && busy) |=> status[7]);

    assert_stop_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> status[4]);

    assert_stop_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_start || ev_rstart) && !ev_stop) |=> !status[4]);
endmodule

bind twi_status_flags twi_status_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_start       (ev_start),
    .ev_rstart      (ev_rstart),
    .ev_stop        (ev_stop),
    .ev_mtx_begin   (ev_mtx_begin),
    .ev_collision   (ev_collision),
    .ev_gcall_match (ev_gcall_match),
    .ev_txwr        (ev_txwr),
    .busy           (busy),
    .status         (status)
);

// File: tb/twi_status_flags_tb.sv
module twi_status_flags_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_ack_slot = 0, ack_nack = 0;
    logic        ev_mtx_begin = 0, ev_collision = 0, ev_addr_match = 0, ev_gcall_match = 0;
    logic        ev_addr10_hi = 0, ev_slave_rx = 0, ev_xfer = 0, hold_full = 0;
    logic        ev_txwr = 0, busy = 0;
    logic [15:0] clr_mask = 0;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_status_flags dut_i (.*);

    task automatic idle();
        ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_ack_slot = 0; ack_nack = 0;
        ev_mtx_begin = 0; ev_collision = 0; ev_addr_match = 0; ev_gcall_match = 0;
        ev_addr10_hi = 0; ev_slave_rx = 0; ev_xfer = 0; hold_full = 0;
        ev_txwr = 0; busy = 0; clr_mask = 0;
    endtask

    // next value of one flag: set wins over clear (R12)
    function automatic logic nxt(logic cur, logic s, logic c);
        return s ? 1'b1 : (c ? 1'b0 : cur);
    endfunction

    // driver: inputs already placed at a negedge; update model, clock, push
    task automatic cycle(string tag);
        logic [15:0] m;
        m = model;
        m[15] = ev_ack_slot ? ack_nack : model[15];
        m[14] = nxt(model[14], ev_mtx_begin, ev_ack_slot);
        m[10] = nxt(model[10], ev_collision, clr_mask[10]);
        m[9]  = nxt(model[9], ev_gcall_match, ev_stop);
        m[8]  = nxt(model[8], ev_addr10_hi, ev_stop);
        m[7]  = nxt(model[7], ev_txwr && busy, clr_mask[7]);
        m[6]  = nxt(model[6], ev_xfer && hold_full, clr_mask[6]);
        m[5]  = nxt(model[5], ev_txwr || ev_slave_rx, ev_addr_match);
        m[4]  = nxt(model[4], ev_stop, ev_start || ev_rstart);
        model = m;
        @(posedge clk);
        #1;
        exp_q.push_back(m);
        tag_q.push_back(tag);
        @(negedge clk);
        idle();
    endtask

    // monitor: compare on falling edges
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (status !== e) begin
                errors++;
                $display("FAIL %s: status=%h expected=%h", t, status, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: status=%h expected=completion", status);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (status !== 16'h0) begin
            errors++;
            $display("FAIL R1: status=%h expected=0000", status);
        end

        // R2 / R3: master transmit, NACK then ACK
        ev_mtx_begin = 1;                     cycle("R3 trx set");
        ev_ack_slot = 1; ack_nack = 1;        cycle("R2 R3 nack, trx clear");
        cycle("R2 hold");
        ev_mtx_begin = 1;                     cycle("R3 trx set again");
        ev_ack_slot = 1; ack_nack = 0;        cycle("R2 ack");
        // R12 on trx
        ev_mtx_begin = 1; ev_ack_slot = 1; ack_nack = 1; cycle("R12 trx set wins");
        // R4
        ev_collision = 1;                     cycle("R4 bcol set");
        ev_stop = 1; ev_start = 0;            cycle("R4 R10 bcol survives stop");
        clr_mask = 16'h0400;                  cycle("R4 bcol sw clear");
        ev_collision = 1; clr_mask = 16'h0400; cycle("R12 bcol set wins");
        clr_mask = 16'h0400;                  cycle("R4 clear");
        // R5 / R6 / R10
        ev_start = 1;                         cycle("R10 stop clr by start");
        ev_gcall_match = 1; ev_addr10_hi = 1; cycle("R5 R6 set");
        clr_mask = 16'hFFFF;                  cycle("R11 full mask on hw flags");
        ev_rstart = 1;                        cycle("R5 R6 hold over rstart");
        ev_stop = 1;                          cycle("R5 R6 R10 stop");
        ev_rstart = 1;                        cycle("R10 stop clr by rstart");
        ev_stop = 1; ev_gcall_match = 1;      cycle("R12 gcall set wins");
        ev_start = 1;                         cycle("R10 clear");
        ev_stop = 1;                          cycle("R5 clear");
        // R7 / R9
        ev_txwr = 1; busy = 0;                cycle("R7 R9 write idle");
        ev_addr_match = 1;                    cycle("R9 da clear");
        ev_txwr = 1; busy = 1;                cycle("R7 wcol set");
        clr_mask = 16'hFF7F;                  cycle("R11 mask without bit7");
        clr_mask = 16'h0080;                  cycle("R7 sw clear");
        ev_addr_match = 1;                    cycle("R9 clear");
        ev_slave_rx = 1;                      cycle("R9 slave rx");
        ev_slave_rx = 1; ev_addr_match = 1;   cycle("R12 da set wins");
        // R8
        ev_xfer = 1; hold_full = 0;           cycle("R8 empty no ovf");
        hold_full = 1;                        cycle("R8 qualifier alone");
        ev_xfer = 1; hold_full = 1;           cycle("R8 ovf set");
        clr_mask = 16'h0040;                  cycle("R8 sw clear");
        // R11: all flags set, non-clearable mask bits only
        ev_ack_slot = 1; ack_nack = 1; ev_collision = 1; ev_gcall_match = 1;
        ev_addr10_hi = 1; ev_txwr = 1; busy = 1; ev_xfer = 1; hold_full = 1;
        ev_stop = 1;                          cycle("R11 load all");
        ev_mtx_begin = 1;                     cycle("R11 trx");
        clr_mask = 16'hFB3F;                  cycle("R11 ignored bits");
        clr_mask = 16'h04C0;                  cycle("R4 R7 R8 group clear");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule